// File: doc/BRIEF.md
# Codec Reset and Power-Down Output Sequencer

This block decides what the converter datapaths of a stereo audio codec may present at their outputs while the chip comes out of power-on reset, while either converter is powered down, and while each converter recovers afterwards. The analog-to-digital path (ADC) and the digital-to-analog path (DAC) are sequenced separately. Each path has a state machine with four states: reset, release wait, settle and run. The release wait is timed in system-clock cycles. The settle phase is timed in sample periods, and each path has its own settle length. During settle the DAC output sits at mid-scale and the ADC output words stay at zero.

Each path has an active-low power-down request. These pins are asynchronous, so they are synchronized and then qualified against a minimum low width, which filters out short glitches. A watchdog runs from a free-running reference clock and notices when the system clock has stopped. If the system clock stops while a power-down request is active, both paths are reset as soon as the clock returns. The block drives a reset line for each path, a mode code for the DAC output stage and a zero-force flag for the ADC data output. Supply sensing and the analog stages are outside this block.

Top module: `codec_rstseq_top`

## Requirements
- R1: While `rst` is high, both path resets are high, `dac_mode` is 2'b00 (ground) and `adc_zero` is 1. After the first clock edge that samples `rst` low, both path resets fall exactly RST_CYC (default 1024) clock edges later.
- R2: When a path's reset falls, the path enters settle. During settle `dac_mode` is 2'b01 (mid-scale) and `adc_zero` stays 1. The DAC reaches 2'b10 (normal) after DAC_HOLD (default 16384) sample ticks. `adc_zero` falls to 0 after ADC_HOLD (default 18432) sample ticks.
- R3: The settle phase counts `fs_tick` pulses, not clock cycles. A tick that arrives while the path is still in release wait is not counted.
- R4: A power-down pin is synchronized and must stay low for at least MIN_PD (default 4) consecutive clock cycles before it resets its path. A low pulse of MIN_PD-1 cycles leaves both paths running.
- R5: While a path's power-down is applied, that path's reset is high. For the DAC this also means `dac_mode` is 2'b00; for the ADC it means `adc_zero` is 1. When the pin returns high, the path repeats the release wait (within RST_CYC plus a few synchronizer cycles) and then the settle phase.
- R6: Powering down one path does not change the other path's reset or output signals.
- R7: If the system clock stops for more than WD_LIMIT (default 16) reference-clock cycles while either power-down pin is low, both paths are reset once the clock resumes, and both then run their full recovery.
- R8: If the system clock stops while neither power-down pin is low, a path that was running stays running.
- R9: `adc_rst` and `dac_rst` are high exactly while their path is in reset or release wait, and they fall on the same edge at which the path enters settle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on indication |
| ref_clk | input | 1 | Free-running reference clock for the clock watchdog |
| ref_rst | input | 1 | Synchronous active-high reset of the reference domain |
| adc_pd_n | input | 1 | Asynchronous ADC power-down request, active low |
| dac_pd_n | input | 1 | Asynchronous DAC power-down request, active low |
| fs_tick | input | 1 | One-cycle pulse per sample period, synchronous to clk |
| adc_rst | output | 1 | Internal reset of the ADC path |
| dac_rst | output | 1 | Internal reset of the DAC path |
| dac_mode | output | 2 | DAC output mode: 00 ground, 01 mid-scale, 10 normal |
| adc_zero | output | 1 | Forces the ADC output words to zero |

## Verification
If a path's state or counter goes wrong, the ports show it as a hold time of the wrong length. For example, a path reset that falls one edge early or late, or a DAC that reaches normal after a different number of sample ticks. The directed checks therefore measure these intervals exactly, counting clock edges and counted ticks. A qualifier or watchdog fault shows up in a different way: a glitch resets a path, or a path fails to drop back into reset. It also shows when one path's power-down disturbs the other path. These faults appear within a few tens of cycles, so every cycle of the neighbouring path's outputs is watched across each power-down window.

// File: rtl/codec_seq_pkg.sv
`timescale 1ns/1ps
package codec_seq_pkg;
  typedef enum logic [1:0] {
    ST_RESET        = 2'd0,
    ST_RELEASE_WAIT = 2'd1,
    ST_SETTLE       = 2'd2,
    ST_RUN          = 2'd3
  } path_state_e;

  typedef enum logic [1:0] {
    DAC_GND  = 2'd0,
    DAC_MID  = 2'd1,
    DAC_PASS = 2'd2
  } dac_mode_e;
endpackage

// File: rtl/codec_pd_qual.sv
`timescale 1ns/1ps
// Synchronizes an asynchronous active-low power-down pin and accepts it
// only after MIN_PD consecutive low cycles.
module codec_pd_qual #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PD      = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pd_n_async,
  output logic pd_active
);
  localparam int QW = $clog2(MIN_PD) + 1;
  localparam logic [QW-1:0] Q_LAST = QW'(MIN_PD - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [QW-1:0]          low_cnt_q;
  logic                   low;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], pd_n_async};
  end

  assign low = ~sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst || !low) begin
      low_cnt_q <= '0;
      pd_active <= 1'b0;
    end else if (low_cnt_q == Q_LAST) begin
      pd_active <= 1'b1;
    end else begin
      low_cnt_q <= low_cnt_q + QW'(1);
    end
  end

  // R4: an applied power-down always follows a synchronized low level
  assert_pd_qual_R4: assert property (@(posedge clk) disable iff (rst)
    pd_active |-> $past(low));
  // R5: once applied, it is dropped only after the pin was seen high
  assert_pd_drop_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(pd_active) |-> !$past(low));
endmodule

// File: rtl/codec_path_fsm.sv
`timescale 1ns/1ps
// Reset -> release wait (clock cycles) -> settle (sample ticks) -> run.
module codec_path_fsm
  import codec_seq_pkg::*;
#(
  parameter int RST_CYC = 1024,
  parameter int HOLD    = 16384
) (
  input  logic clk,
  input  logic rst,
  input  logic force_rst,
  input  logic fs_tick,
  output logic rst_o,
  output logic settle_o,
  output logic run_o
);
  localparam int MAXC = (RST_CYC > HOLD) ? RST_CYC : HOLD;
  localparam int CW   = $clog2(MAXC) + 1;
  localparam logic [CW-1:0] RW_LAST = CW'(RST_CYC - 1);
  localparam logic [CW-1:0] ST_LAST = CW'(HOLD - 1);

  path_state_e   st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (force_rst) begin
      st_d  = ST_RESET;
      cnt_d = '0;
    end else begin
      case (st_q)
        ST_RESET: begin
          st_d  = ST_RELEASE_WAIT;
          cnt_d = '0;
        end
        ST_RELEASE_WAIT: begin
          if (cnt_q == RW_LAST) begin
            st_d  = ST_SETTLE;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        ST_SETTLE: begin
          if (fs_tick) begin
            if (cnt_q == ST_LAST) begin
              st_d  = ST_RUN;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + CW'(1);
            end
          end
        end
        default: st_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_RESET;
      cnt_q    <= '0;
      rst_o    <= 1'b1;
      settle_o <= 1'b0;
      run_o    <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      rst_o    <= (st_d == ST_RESET) || (st_d == ST_RELEASE_WAIT);
      settle_o <= (st_d == ST_SETTLE);
      run_o    <= (st_d == ST_RUN);
    end
  end

  // R5: a forcing request puts the path back into reset on the next edge
  assert_force_R5: assert property (@(posedge clk) disable iff (rst)
    force_rst |=> (rst_o && !settle_o && !run_o));
  // R2: normal operation is reached only through settle
  assert_order_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(run_o) |-> $past(settle_o));
  // R9: settle is entered only from the internal-reset phase
  assert_entry_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(settle_o) |-> $past(rst_o));
  // R3: the settle counter never passes its hold length
  assert_cnt_R3: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SETTLE) |-> (cnt_q < CW'(HOLD)));
endmodule

// File: rtl/codec_clk_watch.sv
`timescale 1ns/1ps
// Missing-clock watchdog: the reference domain watches a toggle from clk.
// A loss seen during power-down is handed to clk with a 4-phase handshake.
module codec_clk_watch #(
  parameter int SYNC_STAGES = 2,
  parameter int WD_LIMIT    = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_clk,
  input  logic ref_rst,
  input  logic adc_pd_n,
  input  logic dac_pd_n,
  output logic clk_lost
);
  localparam int WW = $clog2(WD_LIMIT + 1);
  localparam logic [WW-1:0] W_LAST = WW'(WD_LIMIT);

  // system-clock side
  logic                   alive_q;
  logic [SYNC_STAGES-1:0] lost_sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      alive_q     <= 1'b0;
      lost_sync_q <= '0;
    end else begin
      alive_q     <= ~alive_q;
      lost_sync_q <= {lost_sync_q[SYNC_STAGES-2:0], lost_q};
    end
  end

  assign clk_lost = lost_sync_q[SYNC_STAGES-1];

  // reference side
  logic [SYNC_STAGES:0]   alive_sync_q;
  logic [SYNC_STAGES-1:0] pd_sync_q;
  logic [SYNC_STAGES-1:0] ack_sync_q;
  logic [WW-1:0]          idle_q;
  logic                   lost_q;
  logic                   pd_any, ack, seen;

  assign pd_any = pd_sync_q[SYNC_STAGES-1];
  assign ack    = ack_sync_q[SYNC_STAGES-1];
  assign seen   = alive_sync_q[SYNC_STAGES] ^ alive_sync_q[SYNC_STAGES-1];

  always_ff @(posedge ref_clk) begin
    if (ref_rst) begin
      alive_sync_q <= '0;
      pd_sync_q    <= '0;
      ack_sync_q   <= '0;
      idle_q       <= '0;
      lost_q       <= 1'b0;
    end else begin
      alive_sync_q <= {alive_sync_q[SYNC_STAGES-1:0], alive_q};
      pd_sync_q    <= {pd_sync_q[SYNC_STAGES-2:0], ~(adc_pd_n & dac_pd_n)};
      ack_sync_q   <= {ack_sync_q[SYNC_STAGES-2:0], clk_lost};
      if (seen)                 idle_q <= '0;
      else if (idle_q != W_LAST) idle_q <= idle_q + WW'(1);
      if (ack)                                          lost_q <= 1'b0;
      else if (idle_q == W_LAST && pd_any && !seen)     lost_q <= 1'b1;
    end
  end

  // R7: a loss is raised only while a power-down is applied
  assert_loss_pd_R7: assert property (@(posedge ref_clk) disable iff (ref_rst)
    $rose(lost_q) |-> $past(pd_any));
  // R8: a loss is raised only after the full idle window
  assert_loss_idle_R8: assert property (@(posedge ref_clk) disable iff (ref_rst)
    $rose(lost_q) |-> ($past(idle_q) == W_LAST));
endmodule

// File: rtl/codec_rstseq_top.sv
`timescale 1ns/1ps
module codec_rstseq_top
  import codec_seq_pkg::*;
#(
  parameter int RST_CYC     = 1024,
  parameter int ADC_HOLD    = 18432,
  parameter int DAC_HOLD    = 16384,
  parameter int MIN_PD      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int WD_LIMIT    = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_clk,
  input  logic       ref_rst,
  input  logic       adc_pd_n,
  input  logic       dac_pd_n,
  input  logic       fs_tick,
  output logic       adc_rst,
  output logic       dac_rst,
  output logic [1:0] dac_mode,
  output logic       adc_zero
);
  localparam int NPATH = 2; // index 0: ADC, index 1: DAC

  logic [NPATH-1:0] pin_n, pd_act, hold, p_rst, p_settle, p_run;
  logic             clk_lost;

  assign pin_n = {dac_pd_n, adc_pd_n};

  codec_clk_watch #(
    .SYNC_STAGES (SYNC_STAGES),
    .WD_LIMIT    (WD_LIMIT)
  ) watch_i (
    .clk      (clk),
    .rst      (rst),
    .ref_clk  (ref_clk),
    .ref_rst  (ref_rst),
    .adc_pd_n (adc_pd_n),
    .dac_pd_n (dac_pd_n),
    .clk_lost (clk_lost)
  );

  for (genvar g = 0; g < NPATH; g++) begin : g_path
    localparam int HOLD_G = (g == 0) ? ADC_HOLD : DAC_HOLD;

    codec_pd_qual #(
      .SYNC_STAGES (SYNC_STAGES),
      .MIN_PD      (MIN_PD)
    ) qual_i (
      .clk        (clk),
      .rst        (rst),
      .pd_n_async (pin_n[g]),
      .pd_active  (pd_act[g])
    );

    assign hold[g] = rst | clk_lost | pd_act[g];

    codec_path_fsm #(
      .RST_CYC (RST_CYC),
      .HOLD    (HOLD_G)
    ) fsm_i (
      .clk       (clk),
      .rst       (rst),
      .force_rst (hold[g]),
      .fs_tick   (fs_tick),
      .rst_o     (p_rst[g]),
      .settle_o  (p_settle[g]),
      .run_o     (p_run[g])
    );
  end

  assign adc_rst  = p_rst[0];
  assign adc_zero = ~p_run[0];
  assign dac_rst  = p_rst[1];
  always_comb begin
    if (p_run[1])         dac_mode = DAC_PASS;
    else if (p_settle[1]) dac_mode = DAC_MID;
    else                  dac_mode = DAC_GND;
  end

  // R5: a DAC in internal reset is always grounded
  assert_dac_gnd_R5: assert property (@(posedge clk) disable iff (rst)
    dac_rst |-> (dac_mode == DAC_GND));
  // R6: an ADC power-down alone never stops a running DAC
  assert_indep_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(p_run[1]) && !pd_act[1] && !clk_lost && !$past(hold[1]))
      |-> (dac_mode == DAC_PASS));
  // R2: ADC data is released only out of a finished reset
  assert_adc_rel_R2: assert property (@(posedge clk) disable iff (rst)
    !adc_zero |-> !adc_rst);
endmodule

// File: tb/codec_rstseq_top_tb_top.sv
`timescale 1ns/1ps
module codec_rstseq_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int REF_PERIOD = 14;
  localparam int RST_CYC    = 1024;
  localparam int ADC_HOLD   = 18432;
  localparam int DAC_HOLD   = 16384;
  localparam int MIN_PD     = 4;
  localparam int WD_LIMIT   = 16;

  logic clk = 1'b0, ref_clk = 1'b0, clk_en = 1'b1;
  logic rst = 1'b1, ref_rst = 1'b1;
  logic adc_pd_n = 1'b1, dac_pd_n = 1'b1, fs_tick = 1'b0;
  logic adc_rst, dac_rst, adc_zero;
  logic [1:0] dac_mode;

  int n_chk = 0, n_fail = 0;
  int tick_per = 1, tick_cnt = 0;

  initial forever #(CLK_PERIOD/2) if (clk_en) clk = ~clk;
  initial forever #(REF_PERIOD/2) ref_clk = ~ref_clk;

  always @(negedge clk) begin
    tick_cnt = (tick_cnt + 1 >= tick_per) ? 0 : tick_cnt + 1;
    fs_tick  = (tick_cnt == 0);
  end

  codec_rstseq_top #(
    .RST_CYC(RST_CYC), .ADC_HOLD(ADC_HOLD), .DAC_HOLD(DAC_HOLD),
    .MIN_PD(MIN_PD), .SYNC_STAGES(2), .WD_LIMIT(WD_LIMIT)
  ) dut_i (
    .clk(clk), .rst(rst), .ref_clk(ref_clk), .ref_rst(ref_rst),
    .adc_pd_n(adc_pd_n), .dac_pd_n(dac_pd_n), .fs_tick(fs_tick),
    .adc_rst(adc_rst), .dac_rst(dac_rst), .dac_mode(dac_mode),
    .adc_zero(adc_zero)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic stop_clk(input int ref_cycles);
    @(negedge clk);
    clk_en = 1'b0;
    #(REF_PERIOD * ref_cycles);
    clk_en = 1'b1;
  endtask

  // R1 reset state and release timing, R2 settle lengths, R9
  task automatic t_por();
    int n, t, dac_t;
    bit bad_mid;
    tick_per = 1;
    repeat (6) @(posedge clk);
    #1;
    chk(adc_rst && dac_rst, "R1 resets high in reset", {adc_rst, dac_rst}, 3);
    chk(dac_mode == 2'b00, "R1 dac grounded in reset", dac_mode, 0);
    chk(adc_zero == 1'b1, "R1 adc zero in reset", adc_zero, 1);
    @(negedge clk); rst = 1'b0; ref_rst = 1'b0;
    @(posedge clk);
    n = 0;
    do begin @(posedge clk); n++; #1; end while (adc_rst && n < 5000);
    chk(n == RST_CYC, "R1 release edge count", n, RST_CYC);
    chk(!dac_rst, "R9 both resets fall together", dac_rst, 0);
    chk(dac_mode == 2'b01, "R2 dac mid-scale in settle", dac_mode, 1);
    chk(adc_zero == 1'b1, "R2 adc zero in settle", adc_zero, 1);
    t = 0; dac_t = -1; bad_mid = 0;
    do begin
      @(posedge clk);
      if (fs_tick) t++;
      #1;
      if (dac_t < 0 && dac_mode == 2'b10) dac_t = t;
      if (dac_t < 0 && dac_mode != 2'b01) bad_mid = 1;
    end while (adc_zero && t < 30000);
    chk(dac_t == DAC_HOLD, "R2 dac settle ticks", dac_t, DAC_HOLD);
    chk(t == ADC_HOLD, "R2 adc settle ticks", t, ADC_HOLD);
    chk(!bad_mid, "R2 dac held mid-scale until normal", bad_mid, 0);
  endtask

  // R4 short pulses are ignored
  task automatic t_glitch();
    bit bad = 0;
    @(negedge clk); adc_pd_n = 1'b0;
    repeat (MIN_PD - 1) @(negedge clk);
    adc_pd_n = 1'b1;
    repeat (12) begin @(posedge clk); #1; if (adc_zero || adc_rst) bad = 1; end
    chk(!bad, "R4 adc glitch ignored", bad, 0);
    bad = 0;
    @(negedge clk); dac_pd_n = 1'b0;
    repeat (MIN_PD - 1) @(negedge clk);
    dac_pd_n = 1'b1;
    repeat (12) begin @(posedge clk); #1; if (dac_mode != 2'b10 || dac_rst) bad = 1; end
    chk(!bad, "R4 dac glitch ignored", bad, 0);
  endtask

  // R5 ADC power-down and recovery, R6 DAC unaffected
  task automatic t_adc_pd();
    int n, t;
    bit dac_bad = 0;
    tick_per = 1;
    @(negedge clk); adc_pd_n = 1'b0;
    repeat (10) begin @(posedge clk); #1; if (dac_mode != 2'b10 || dac_rst) dac_bad = 1; end
    chk(adc_rst && adc_zero, "R5 adc held in reset", {adc_rst, adc_zero}, 3);
    repeat (40) begin @(posedge clk); #1; if (dac_mode != 2'b10 || dac_rst) dac_bad = 1; end
    @(negedge clk); adc_pd_n = 1'b1;
    n = 0;
    do begin
      @(posedge clk); n++; #1;
      if (dac_mode != 2'b10 || dac_rst) dac_bad = 1;
    end while (adc_rst && n < 3000);
    chk(n >= RST_CYC && n <= RST_CYC + 8, "R5 adc release wait", n, RST_CYC);
    t = 0;
    do begin
      @(posedge clk);
      if (fs_tick) t++;
      #1;
      if (dac_mode != 2'b10 || dac_rst) dac_bad = 1;
    end while (adc_zero && t < 30000);
    chk(t == ADC_HOLD, "R5 adc settle ticks after power-down", t, ADC_HOLD);
    chk(!dac_bad, "R6 dac untouched by adc power-down", dac_bad, 0);
  endtask

  // R4 minimum pulse accepted, R3 tick counting, R6 ADC unaffected
  task automatic t_dac_pd();
    int t, c, n;
    bit saw_gnd = 0, adc_bad = 0, mid_bad = 0;
    tick_per = 3;
    @(negedge clk); dac_pd_n = 1'b0;
    repeat (MIN_PD) @(negedge clk);
    dac_pd_n = 1'b1;
    repeat (10) begin
      @(posedge clk); #1;
      if (dac_mode == 2'b00 && dac_rst) saw_gnd = 1;
      if (adc_zero || adc_rst) adc_bad = 1;
    end
    chk(saw_gnd, "R4 pulse of MIN_PD cycles resets dac", saw_gnd, 1);
    n = 0;
    do begin
      @(posedge clk); n++; #1;
      if (adc_zero || adc_rst) adc_bad = 1;
    end while (dac_rst && n < 3000);
    chk(!dac_rst, "R5 dac reset released", dac_rst, 0);
    t = 0; c = 0;
    do begin
      @(posedge clk); c++;
      if (fs_tick) t++;
      #1;
      if (dac_mode != 2'b10 && dac_mode != 2'b01) mid_bad = 1;
      if (adc_zero || adc_rst) adc_bad = 1;
    end while (dac_mode != 2'b10 && t < 30000);
    chk(t == DAC_HOLD, "R3 dac settle counts ticks", t, DAC_HOLD);
    chk(c >= 3 * (DAC_HOLD - 1), "R3 sparse ticks stretch settle", c, 3 * DAC_HOLD);
    chk(!mid_bad, "R2 dac mid-scale during sparse settle", mid_bad, 0);
    chk(!adc_bad, "R6 adc untouched by dac power-down", adc_bad, 0);
    tick_per = 1;
  endtask

  // R8 clock stop without power-down has no effect
  task automatic t_clk_idle();
    bit bad = 0;
    stop_clk(100);
    repeat (30) begin @(posedge clk); #1; if (adc_zero || dac_mode != 2'b10) bad = 1; end
    chk(!bad, "R8 clock stop while active ignored", bad, 0);
  endtask

  // R7 clock stop during power-down resets both paths
  task automatic t_clk_pd();
    bit adc_hit = 0;
    int n;
    tick_per = 1;
    @(negedge clk); dac_pd_n = 1'b0;
    repeat (20) @(posedge clk);
    #1;
    chk(!adc_rst && !adc_zero, "R6 adc running before clock stop", adc_zero, 0);
    stop_clk(WD_LIMIT * 6);
    repeat (30) begin @(posedge clk); #1; if (adc_rst && adc_zero) adc_hit = 1; end
    chk(adc_hit, "R7 adc reset after lost clock", adc_hit, 1);
    @(negedge clk); dac_pd_n = 1'b1;
    n = 0;
    do begin @(posedge clk); n++; #1; end
    while ((adc_zero || dac_mode != 2'b10) && n < 25000);
    chk(!adc_zero, "R7 adc recovers after lost clock", adc_zero, 0);
    chk(dac_mode == 2'b10, "R7 dac recovers after lost clock", dac_mode, 2);
  endtask

  initial begin
    #(CLK_PERIOD * 195000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    t_por();
    t_glitch();
    t_adc_pd();
    t_dac_pd();
    t_clk_idle();
    t_clk_pd();
    summary();
    $finish;
  end
endmodule